// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between an A side and a B side, with a separate path for each direction. Each path has one storage register. That register can work as a transparent latch, as a held latch, or as a register loaded on a clock edge. Which of these it does depends on a level-sensitive latch enable and a capture clock belonging to that path. Each path also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The bus pins are modelled without internal tri-states. Each direction gives a data vector and a drive flag, and a pad wrapper can merge the two onto a bidirectional pin. The latch enables, capture clocks and output enables may change at any time. A system clock much faster than these controls samples them, and every effect of a control change shows up after the first system-clock edge that sees the change. In transparent mode, data changes pass straight through to the output with no register in the way.

Top module: `latched_bus_xcvr`

## Requirements
- R1: Each direction carries a DATA_W-bit word (default 18). Activity on one direction never changes the data or the drive flag of the other direction.
- R2: After a system-clock edge that samples the latch enable of a direction high, that direction's output equals its input in the same cycle, and it follows input changes with no added clock delay.
- R3: When the latch enable is low, a system-clock edge that samples the capture clock at 1, where the previous sample was 0, stores the input present at that edge. The output shows the stored word after that edge.
- R4: While the latch enable is low and the capture clock is steady high or steady low, the output holds the stored word and ignores the input. A falling capture clock also loads nothing.
- R5: When the latch enable drops, the output keeps the last value it passed in transparent mode. This holds whether the capture clock is high or low at that moment.
- R6: The A-to-B drive flag is 1 after an edge that samples the A-to-B output enable at 1, and 0 after an edge that samples it at 0. Storage keeps working while the output is disabled.
- R7: The B-to-A path follows R2 to R5 with its own latch enable and capture clock. Its drive flag is 1 after an edge that samples its enable at 0, and 0 after an edge that samples it at 1.
- R8: A synchronous reset clears both stored words to zero and sets both drive flags to 0. If a capture clock is already high when reset is released, that does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples the controls |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | DATA_W | Value seen on the A side pins |
| bIn | input | DATA_W | Value seen on the B side pins |
| abLatchEn | input | 1 | A-to-B latch enable, 1 means transparent |
| abCapClk | input | 1 | A-to-B capture clock, rising edge stores |
| abOutEn | input | 1 | A-to-B output enable, active high |
| baLatchEn | input | 1 | B-to-A latch enable, 1 means transparent |
| baCapClk | input | 1 | B-to-A capture clock, rising edge stores |
| baOutEnN | input | 1 | B-to-A output enable, active low |
| bData | output | DATA_W | Value to drive onto the B side |
| bDrive | output | 1 | 1 when the B side pins are driven |
| aData | output | DATA_W | Value to drive onto the A side |
| aDrive | output | 1 | 1 when the A side pins are driven |

## Verification
The hardest case to reach is the moment the latch enable drops. This must be tested once with the capture clock high and once with it low, and the input must already differ from the last value passed, so that a wrong load would show. The vector table reaches it by first putting a known word through in transparent mode, then changing the input in the same step that lowers the enable. A second hard case is a capture clock already high when reset is released. A directed test sets this up by holding the clock high through reset, and then checks that the stored zero survives.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from the control module of one direction to its datapath.
  typedef struct packed {
    logic load;   // store the input word at this edge
    logic pass;   // output follows the input (transparent)
    logic drive;  // output pins are driven
  } xferStrb_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xcvr_pkg::*;
#(
  parameter bit OE_ACTIVE_HIGH = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      latchEn,
  input  logic      capClk,
  input  logic      outEn,
  output xferStrb_t strb
);
  logic oeAct;
  logic leQ;
  logic ckQ;
  logic oeQ;

  generate
    if (OE_ACTIVE_HIGH) begin : g_oeHigh
      assign oeAct = outEn;
    end else begin : g_oeLow
      assign oeAct = ~outEn;
    end
  endgenerate

  // ckQ resets high, so a clock already high when reset is released is not an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      leQ <= 1'b0;
      ckQ <= 1'b1;
      oeQ <= 1'b0;
    end else begin
      leQ <= latchEn;
      ckQ <= capClk;
      oeQ <= oeAct;
    end
  end

  // Transparent mode reloads every cycle, so dropping the enable keeps the last passed word.
  always_comb begin
    strb.load  = latchEn | (capClk & ~ckQ);
    strb.pass  = leQ;
    strb.drive = oeQ;
  end

  AST_DRIVE_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (outEn == OE_ACTIVE_HIGH) |=> strb.drive);  // R6
  AST_NO_LOAD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!latchEn && capClk && $past(capClk) && !$past(rst)) |-> !strb.load);  // R4
endmodule

// File: rtl/xfer_path.sv
module xfer_path
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  xferStrb_t         strb,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  logic [DATA_W-1:0] store;

  always_ff @(posedge clk) begin
    if (rst)           store <= '0;
    else if (strb.load) store <= din;
  end

  assign dout  = strb.pass ? din : store;
  assign drive = strb.drive;

  AST_HOLD_STORE: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(store));  // R4
  AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (store == $past(din)));  // R3
endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              abLatchEn,
  input  logic              abCapClk,
  input  logic              abOutEn,
  input  logic              baLatchEn,
  input  logic              baCapClk,
  input  logic              baOutEnN,
  output logic [DATA_W-1:0] bData,
  output logic              bDrive,
  output logic [DATA_W-1:0] aData,
  output logic              aDrive
);
  xferStrb_t abStrb;
  xferStrb_t baStrb;

  xfer_ctrl #(.OE_ACTIVE_HIGH(1'b1)) u_abCtrl (
    .clk(clk), .rst(rst), .latchEn(abLatchEn), .capClk(abCapClk),
    .outEn(abOutEn), .strb(abStrb));

  xfer_path #(.DATA_W(DATA_W)) u_abPath (
    .clk(clk), .rst(rst), .din(aIn), .strb(abStrb),
    .dout(bData), .drive(bDrive));

  xfer_ctrl #(.OE_ACTIVE_HIGH(1'b0)) u_baCtrl (
    .clk(clk), .rst(rst), .latchEn(baLatchEn), .capClk(baCapClk),
    .outEn(baOutEnN), .strb(baStrb));

  xfer_path #(.DATA_W(DATA_W)) u_baPath (
    .clk(clk), .rst(rst), .din(bIn), .strb(baStrb),
    .dout(aData), .drive(aDrive));

  AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    abLatchEn |=> (bData == aIn));  // R2
  AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    baLatchEn |=> (aData == bIn));  // R7
  AST_AB_OFF: assert property (@(posedge clk) disable iff (rst)
    !abOutEn |=> !bDrive);  // R6
  AST_BA_OFF: assert property (@(posedge clk) disable iff (rst)
    baOutEnN |=> !aDrive);  // R7
endmodule

// File: tb/latched_bus_xcvr_bench.sv
module latched_bus_xcvr_bench;
  localparam int W = 18;

  typedef struct packed {
    logic         le;
    logic         ck;
    logic         oe;
    logic [W-1:0] a;
    logic [W-1:0] expB;
    logic         expDrv;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 18'h11111, 18'h11111, 1'b1},  // R2
    '{1'b1, 1'b0, 1'b1, 18'h22222, 18'h22222, 1'b1},  // R2
    '{1'b0, 1'b0, 1'b1, 18'h33333, 18'h22222, 1'b1},  // R5 clock low
    '{1'b0, 1'b0, 1'b1, 18'h3ABCD, 18'h22222, 1'b1},  // R4
    '{1'b0, 1'b1, 1'b1, 18'h15A5A, 18'h15A5A, 1'b1},  // R3
    '{1'b0, 1'b1, 1'b1, 18'h00F0F, 18'h15A5A, 1'b1},  // R4 steady high
    '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h15A5A, 1'b1},  // R4 falling
    '{1'b0, 1'b1, 1'b1, 18'h2AAAA, 18'h2AAAA, 1'b1},  // R3
    '{1'b1, 1'b1, 1'b1, 18'h12345, 18'h12345, 1'b1},  // R2
    '{1'b0, 1'b1, 1'b1, 18'h0FEDC, 18'h12345, 1'b1},  // R5 clock high
    '{1'b0, 1'b1, 1'b0, 18'h0FEDC, 18'h12345, 1'b0},  // R6
    '{1'b0, 1'b0, 1'b0, 18'h0FEDC, 18'h12345, 1'b0},  // R6
    '{1'b0, 1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3, 1'b0},  // R6 capture while off
    '{1'b0, 1'b1, 1'b1, 18'h00000, 18'h3C3C3, 1'b1}   // R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic abLatchEn = 1'b0, abCapClk = 1'b0, abOutEn = 1'b1;
  logic baLatchEn = 1'b0, baCapClk = 1'b0, baOutEnN = 1'b0;
  logic [W-1:0] bData, aData;
  logic bDrive, aDrive;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  latched_bus_xcvr #(.DATA_W(W)) u_latched_bus_xcvr (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn),
    .abLatchEn(abLatchEn), .abCapClk(abCapClk), .abOutEn(abOutEn),
    .baLatchEn(baLatchEn), .baCapClk(baCapClk), .baOutEnN(baOutEnN),
    .bData(bData), .bDrive(bDrive), .aData(aData), .aDrive(aDrive));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset state, with enables requesting drive
    #1;
    tick();
    tick();
    check("R8 bDrive", W'(bDrive), W'(1'b0));
    check("R8 aDrive", W'(aDrive), W'(1'b0));
    check("R8 bData", bData, '0);
    check("R8 aData", aData, '0);
    rst = 1'b0;

    // Vector table, A-to-B; B-to-A stays idle (R1)
    for (int i = 0; i < NV; i++) begin
      abLatchEn = VECS[i].le;
      abCapClk  = VECS[i].ck;
      abOutEn   = VECS[i].oe;
      aIn       = VECS[i].a;
      tick();
      check($sformatf("R2-5 vec%0d bData", i), bData, VECS[i].expB);
      check($sformatf("R6 vec%0d bDrive", i), W'(bDrive), W'(VECS[i].expDrv));
      check($sformatf("R1 vec%0d aData", i), aData, '0);
    end

    // R2 input change passes without a clock
    abLatchEn = 1'b1;
    tick();
    aIn = 18'h2468A;
    #1;
    check("R2 combinational follow", bData, 18'h2468A);

    // R7 B-to-A direction, active-low enable
    baOutEnN = 1'b1;
    tick();
    check("R7 aDrive off", W'(aDrive), W'(1'b0));
    baOutEnN = 1'b0;
    baLatchEn = 1'b1;
    bIn = 18'h1F00F;
    tick();
    check("R7 aDrive on", W'(aDrive), W'(1'b1));
    check("R7 transparent", aData, 18'h1F00F);
    check("R1 B side unaffected", bData, 18'h2468A);
    baLatchEn = 1'b0;
    bIn = 18'h00777;
    tick();
    check("R7 hold after drop", aData, 18'h1F00F);
    baCapClk = 1'b1;
    tick();
    check("R7 capture", aData, 18'h00777);
    bIn = 18'h3000F;
    tick();
    check("R7 steady clock hold", aData, 18'h00777);

    // R8 capture clock high through reset: no edge on release
    abLatchEn = 1'b0;
    abCapClk = 1'b1;
    rst = 1'b1;
    tick();
    rst = 1'b0;
    aIn = 18'h11111;
    tick();
    check("R8 no capture after reset", bData, '0);
    tick();
    check("R8 still zero", bData, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule